// File: doc/BRIEF.md
# MDIO Management Transaction Engine

This block carries out one management transaction at a time between the chip and an external PHY over a two-wire serial management link. Software writes a 32-bit command word into the command/data register. The word carries the start pattern, the opcode, the PHY address, the register number, the turnaround pattern and the 16-bit data, each at a fixed bit position. If the block is idle and the clock divider is programmed, this write starts the transaction. The engine first sends a run of ones as a preamble, then shifts the command word out most significant bit first. On a read it lets go of the data line for the turnaround and data bits, and collects the 16 bits that the PHY returns.

When the last bit period ends, the returned data replaces the low half of the command/data register and a completion flag is raised in the event register. Software clears that flag by writing a one to it. A divider register sets the management clock to the system clock divided by twice its value. A divider value of zero stops the management clock and refuses new commands. Three design modules sit under the top: a package holding the state type and the field positions, the management clock generator, and the shift engine.

The shift engine is a three-state machine. `ST_IDLE` moves to `ST_PRE` on an accepted command. `ST_PRE` moves to `ST_FRAME` on the falling management clock edge that ends the last preamble bit. `ST_FRAME` returns to `ST_IDLE` on the falling edge that ends the 32nd frame bit, and that transition is the completion.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command/data register and the event register read zero, and `busy`, `mdc` and `mdio_oe` are low.
- R2: A command write while idle with a nonzero divider stores the word in the command/data register and raises `busy` in the next cycle.
- R3: The management clock has a period of 2×divider system clocks, with equal high and low phases. It stays low whenever `busy` is low.
- R4: A transaction sends exactly 64 bits. The first 32 (PRE_LEN) are ones and the next are the command word, MSB first. Each bit changes only on a falling management clock edge, so it is stable across the rising edge that follows.
- R5: A command whose bits 29:28 equal 2'b10 is a read. A read drives command bits 31:18 and releases the line (`mdio_oe` low) for bits 17:0. Any other opcode is a write, and it drives all 32 bits.
- R6: On a read, bits 15:0 of the command/data register take the 16 bits sampled on the rising edges of frame bits 15..0, first sample into bit 15. Bits 31:16 keep the command. With no PHY the line floats high and the result is 0xFFFF.
- R7: Completion sets event bit 23 in the same cycle that `busy` falls. A write leaves the command/data register unchanged.
- R8: An event-register write with bit 23 set clears the flag. A write with bit 23 clear leaves it set. A completion in the same cycle wins over the clear.
- R9: A command write while `busy` is high is ignored. The register is unchanged, the running transaction finishes with its own result, and no second transaction follows.
- R10: With the divider at zero, a command write starts nothing. `busy` and `mdc` stay low and the register keeps its value.
- R11: The divider is captured when a transaction starts. A divider write during a transaction changes only the transactions that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command/data register |
| cmd_wdata | input | 32 | Command word |
| spd_we | input | 1 | Write strobe for the divider register |
| spd_wdata | input | SPD_W | Divider value |
| evt_we | input | 1 | Write strobe for the event register (write one to clear) |
| evt_wdata | input | 32 | Event write data; bit 23 clears the completion flag |
| data_q | output | 32 | Command/data register contents |
| evt_q | output | 32 | Event register; bit 23 is the completion flag |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Management data value driven out |
| mdio_oe | output | 1 | Output enable for the management data line |

## Verification
The bench stands in for the PHY. It records the line and its enable on every rising management clock edge, and it returns read data after the turnaround. This catches an engine that drives during the turnaround, shifts LSB first, or samples one bit late; each of these shows up as a wrong enable pattern or a rotated result. Reads with no PHY must come back as 0xFFFF, which exposes a design that clears the receive shifter or samples while it is still driving. A command written mid-transaction, a divider write mid-transaction and a zero divider target engines that restart, change rate partway through, or hang with the clock stopped. The write-one-to-clear flag is probed with both a zero and a one in bit 23, so a plain-write clear is caught.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_FRAME = 2'd2
    } mdio_st_e;

    localparam int          FRAME_W      = 32;
    localparam int          DATA_W       = 16;
    localparam int          OP_HI        = 29;
    localparam int          OP_LO        = 28;
    localparam logic [1:0]  OP_READ      = 2'b10;
    localparam int          TA_HI        = 17;
    localparam int          EVT_DONE_BIT = 23;
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] div,
    output logic             mdc,
    output logic             rise_tk,
    output logic             fall_tk
);
    logic [SPD_W-1:0] cnt;
    logic             wrap;

    assign wrap    = run && (cnt == div - 1'b1);
    assign rise_tk = wrap && !mdc;
    assign fall_tk = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [FRAME_W-1:0]   frame_in,
    input  logic [SPD_W-1:0]     speed,
    input  logic                 mdio_i,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int PRE_CW      = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
    localparam int FR_CW       = $clog2(FRAME_W);
    localparam int CW          = (PRE_CW > FR_CW) ? PRE_CW : FR_CW;
    localparam int RELEASE_IDX = FRAME_W - 1 - TA_HI;
    localparam int SAMPLE_IDX  = FRAME_W - DATA_W;

    mdio_st_e              state, nxt;
    logic [FRAME_W-1:0]    sh;
    logic [CW-1:0]         bitn;
    logic [DATA_W-1:0]     rd_sh;
    logic [SPD_W-1:0]      spd_q;
    logic                  rd_q;
    logic                  run, rise_tk, fall_tk;
    logic                  pre_end, frame_end;

    assign pre_end   = (bitn == CW'(PRE_LEN - 1));
    assign frame_end = (bitn == CW'(FRAME_W - 1));

    mdc_clkgen #(.SPD_W(SPD_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div     (spd_q),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)                nxt = ST_PRE;
            ST_PRE:   if (fall_tk && pre_end)   nxt = ST_FRAME;
            ST_FRAME: if (fall_tk && frame_end) nxt = ST_IDLE;
            default:                            nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PRE: begin
                run     = 1'b1;
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_FRAME: begin
                run     = 1'b1;
                mdio_o  = sh[FRAME_W-1];
                mdio_oe = !rd_q || (bitn < CW'(RELEASE_IDX));
                done    = fall_tk && frame_end;
            end
            default: ;
        endcase
    end

    assign busy    = run;
    assign rd_data = rd_sh;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            bitn  <= '0;
            rd_sh <= '0;
            spd_q <= '0;
            rd_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sh    <= frame_in;
                        bitn  <= '0;
                        spd_q <= speed;
                        rd_q  <= (frame_in[OP_HI:OP_LO] == OP_READ);
                    end
                end
                ST_PRE: begin
                    if (fall_tk) bitn <= pre_end ? '0 : bitn + 1'b1;
                end
                ST_FRAME: begin
                    if (rise_tk && rd_q && (bitn >= CW'(SAMPLE_IDX)))
                        rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
                    if (fall_tk) begin
                        sh   <= {sh[FRAME_W-2:0], 1'b0};
                        bitn <= bitn + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME && rd_q && bitn >= CW'(SAMPLE_IDX)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    input  logic             spd_we,
    input  logic [SPD_W-1:0] spd_wdata,
    input  logic             evt_we,
    input  logic [31:0]      evt_wdata,
    output logic [31:0]      data_q,
    output logic [31:0]      evt_q,
    output logic             busy,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    logic [SPD_W-1:0]  spd_r;
    logic              evt_bit;
    logic              start, done;
    logic [DATA_W-1:0] rd_data;
    logic              evt_wdata_unused;

    assign evt_wdata_unused = ^{evt_wdata[31:EVT_DONE_BIT+1], evt_wdata[EVT_DONE_BIT-1:0]};
    assign start = cmd_we && !busy && (spd_r != '0);

    mdio_engine #(.SPD_W(SPD_W), .PRE_LEN(PRE_LEN)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame_in (cmd_wdata),
        .speed    (spd_r),
        .mdio_i   (mdio_i),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .done     (done),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_r   <= '0;
            data_q  <= '0;
            evt_bit <= 1'b0;
        end else begin
            if (spd_we) spd_r <= spd_wdata;
            if (start)
                data_q <= cmd_wdata;
            else if (done && data_q[OP_HI:OP_LO] == OP_READ)
                data_q[DATA_W-1:0] <= rd_data;
            if (done)
                evt_bit <= 1'b1;
            else if (evt_we && evt_wdata[EVT_DONE_BIT])
                evt_bit <= 1'b0;
        end
    end

    always_comb begin
        evt_q               = '0;
        evt_q[EVT_DONE_BIT] = evt_bit;
    end

    // R3
    mdc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R4
    frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(mdc)) |-> $stable(mdio_o));
    // R7
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt_q[EVT_DONE_BIT]);
    // R8
    evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_we && evt_wdata[EVT_DONE_BIT] && !done) |=> !evt_q[EVT_DONE_BIT]);
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy && !done) |=> $stable(data_q));
    // R10
    zero_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && spd_r == '0 && !busy) |=> !busy);
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
    localparam int SPD_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_we = 1'b0;
    logic [31:0]      cmd_wdata = '0;
    logic             spd_we = 1'b0;
    logic [SPD_W-1:0] spd_wdata = '0;
    logic             evt_we = 1'b0;
    logic [31:0]      evt_wdata = '0;
    logic [31:0]      data_q, evt_q;
    logic             busy, mdc, mdio_o, mdio_oe;
    logic             phy_drv = 1'b1;
    logic             mdio_line;
    logic             evt_bit;

    always #5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : phy_drv;
    assign evt_bit   = evt_q[23];

    mdio_mgmt_ctrl #(.SPD_W(SPD_W), .PRE_LEN(32)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .spd_we(spd_we), .spd_wdata(spd_wdata), .evt_we(evt_we), .evt_wdata(evt_wdata),
        .data_q(data_q), .evt_q(evt_q), .busy(busy), .mdc(mdc),
        .mdio_i(mdio_line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] word;
        logic [31:0] exp_data;
        bit          rd;
        int          spd;
    } exp_t;

    exp_t        sbq[$];
    exp_t        cur;
    logic        cap   [64];
    logic        oecap [64];
    int          edge_n = 0;
    bit          phy_on = 1'b0;
    logic [15:0] phy_val = '0;
    bit          cur_rd = 1'b0;
    bit          have_rise = 1'b0;
    time         last_rise = 0;
    int          per = 0;

    // PHY model: observe on rising MDC, answer reads after turnaround
    always @(posedge mdc) begin
        if (edge_n < 64) begin
            cap[edge_n]   = mdio_line;
            oecap[edge_n] = mdio_oe;
        end
        if (have_rise) per = int'(($time - last_rise) / 10);
        have_rise = 1'b1;
        last_rise = $time;
        if (phy_on && cur_rd && edge_n >= 47 && edge_n <= 62)
            phy_drv <= phy_val[62 - edge_n];
        else
            phy_drv <= 1'b1;
        edge_n++;
    end

    // monitor: pop and compare on every completion
    initial begin
        forever begin
            @(posedge evt_bit);
            @(negedge clk);
            if (sbq.size() == 0) begin
                chk(1'b0, "R7", "completion without command", 32'd1, 32'd0);
            end else begin
                bit pre_ok, frm_ok, oe_ok;
                cur = sbq.pop_front();
                chk(data_q == cur.exp_data, cur.rd ? "R6" : "R7", "result register",
                    data_q, cur.exp_data);
                chk(edge_n == 64, "R4", "rising edge count", edge_n, 64);
                pre_ok = 1'b1;
                frm_ok = 1'b1;
                oe_ok  = 1'b1;
                for (int e = 0; e < 32; e++)
                    if (cap[e] !== 1'b1 || oecap[e] !== 1'b1) pre_ok = 1'b0;
                for (int j = 0; j < 32; j++) begin
                    if (cur.rd && j >= 14) begin
                        if (oecap[32+j] !== 1'b0) oe_ok = 1'b0;
                    end else begin
                        if (oecap[32+j] !== 1'b1) oe_ok = 1'b0;
                        if (cap[32+j] !== cur.word[31-j]) frm_ok = 1'b0;
                    end
                end
                chk(pre_ok, "R4", "preamble of ones", {31'd0, pre_ok}, 32'd1);
                chk(frm_ok, "R4", "frame bits MSB first", {31'd0, frm_ok}, 32'd1);
                chk(oe_ok, "R5", "drive/release pattern", {31'd0, oe_ok}, 32'd1);
                chk(per == 2 * cur.spd, "R3", "MDC period", per, 2 * cur.spd);
            end
        end
    end

    task automatic set_spd(input int v);
        @(negedge clk);
        spd_we = 1'b1;
        spd_wdata = SPD_W'(v);
        @(negedge clk);
        spd_we = 1'b0;
    endtask

    task automatic run_txn(input logic [31:0] word, input int spd,
                           input bit present, input logic [15:0] val);
        exp_t x;
        while (busy) @(negedge clk);
        x.word = word;
        x.rd   = (word[29:28] == 2'b10);
        x.spd  = spd;
        x.exp_data = x.rd ? {word[31:16], (present ? val : 16'hFFFF)} : word;
        phy_on = present;
        phy_val = val;
        cur_rd = x.rd;
        edge_n = 0;
        have_rise = 1'b0;
        sbq.push_back(x);
        cmd_we = 1'b1;
        cmd_wdata = word;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accepted command", {31'd0, busy}, 32'd1);
        chk(data_q == word, "R2", "command stored", data_q, word);
    endtask

    task automatic finish_txn();
        wait (evt_bit);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R7", "busy low with flag set", {31'd0, busy}, 32'd0);
        evt_we = 1'b1;
        evt_wdata = 32'h0080_0000;
        @(negedge clk);
        evt_we = 1'b0;
        evt_wdata = '0;
        chk(evt_bit == 1'b0, "R8", "flag cleared by one", {31'd0, evt_bit}, 32'd0);
    endtask

    bit wd_fired = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        wd_fired = 1'b1;
        chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(data_q == 32'd0, "R1", "data after reset", data_q, 32'd0);
        chk(evt_q == 32'd0, "R1", "event after reset", evt_q, 32'd0);
        chk({busy, mdc, mdio_oe} == 3'b000, "R1", "busy/mdc/oe after reset",
            {29'd0, busy, mdc, mdio_oe}, 32'd0);
        rst_n = 1'b1;

        // write: addr 5, reg 3, data 0x1234
        set_spd(2);
        run_txn(32'h528E_1234, 2, 1'b1, 16'h0);
        finish_txn();

        // read with PHY present: addr 1, reg 2
        set_spd(3);
        run_txn(32'h608A_0000, 3, 1'b1, 16'hA5C3);
        finish_txn();

        // read, no PHY -> 0xFFFF (R6)
        set_spd(1);
        run_txn(32'h6F86_0000, 1, 1'b0, 16'h0);
        finish_txn();

        // R9 / R11: command and divider writes while busy
        set_spd(2);
        run_txn(32'h5A0C_BEEF, 2, 1'b1, 16'h0);
        repeat (40) @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = 32'h6FFF_0000;
        spd_we = 1'b1;
        spd_wdata = SPD_W'(5);
        @(negedge clk);
        cmd_we = 1'b0;
        spd_we = 1'b0;
        chk(data_q == 32'h5A0C_BEEF, "R9", "write while busy ignored", data_q, 32'h5A0C_BEEF);
        chk(busy == 1'b1, "R9", "transaction continues", {31'd0, busy}, 32'd1);
        wait (evt_bit);
        repeat (2) @(negedge clk);
        evt_we = 1'b1;
        evt_wdata = 32'hFF7F_FFFF;
        @(negedge clk);
        evt_we = 1'b0;
        chk(evt_bit == 1'b1, "R8", "bit 23 zero keeps flag", {31'd0, evt_bit}, 32'd1);
        evt_we = 1'b1;
        evt_wdata = 32'h0080_0000;
        @(negedge clk);
        evt_we = 1'b0;
        chk(evt_bit == 1'b0, "R8", "bit 23 one clears flag", {31'd0, evt_bit}, 32'd0);
        repeat (10) @(negedge clk);
        chk({busy, mdc} == 2'b00, "R9", "no second transaction",
            {30'd0, busy, mdc}, 32'd0);

        // R11: divider written mid-transaction applies now
        run_txn(32'h6042_0000, 5, 1'b1, 16'h0001);
        finish_txn();

        // R10: zero divider blocks commands
        set_spd(0);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = 32'h528E_0000;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (20) @(negedge clk);
        chk({busy, mdc} == 2'b00, "R10", "no activity at divider zero",
            {30'd0, busy, mdc}, 32'd0);
        chk(data_q == 32'h6042_0001, "R10", "register kept", data_q, 32'h6042_0001);
        chk(evt_q == 32'd0, "R10", "no completion", evt_q, 32'd0);

        // write with all-ones data, fastest rate
        set_spd(1);
        run_txn(32'h57FF_FFFF, 1, 1'b1, 16'h0);
        finish_txn();

        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, "R7", "every command completed", sbq.size(), 32'd0);
        if (!wd_fired) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule